// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides when an 8-bit timer advances. It emits `cnt_en`, a one-cycle strobe in the system clock domain, and the timer adds one on each cycle the strobe is high. A 3-bit code `src_sel` picks where the strobe comes from. The strobe can be held off. It can fire on every clock. It can come from one of four power-of-two taps of a shared free-running prescaler. It can also follow an external pin, on the edge polarity that the code selects.

The external pin is always sampled, whatever its pad direction. Firmware can therefore drive the pin and clock the timer by hand. The pin passes through a two-flop synchronizer and one more register for edge detection. A strobe strobe `pre_clr` restarts the prescaler so that a divided count can begin at a known phase. It leaves the rest of the block alone.

Top module: `tmr_clk_select`

## Requirements
- R1: With `src_sel` = 3'b000, `cnt_en` stays low.
- R2: With `src_sel` = 3'b001, `cnt_en` is high on every cycle that follows a clock edge at which that code was present.
- R3: With `src_sel` = 3'b010, 3'b011, 3'b100 or 3'b101, `cnt_en` is high for exactly the cycle that follows an edge at which the prescaler count has its low 3, 6, 8 or 10 bits all ones. This gives division by 8, 64, 256 and 1024.
- R4: The prescaler is a 10-bit counter. It counts up on every clock whatever the select code, so its phase carries across code changes. After a restart, a fixed divided code yields exactly 2048/N strobes in 2048 cycles.
- R5: With `src_sel` = 3'b110, each falling edge of `ext_pin` yields one strobe. That strobe is high in the cycle after the second clock edge following the edge at which the new low level was first sampled.
- R6: With `src_sel` = 3'b111, each rising edge of `ext_pin` yields one strobe, with the same delay as in R5.
- R7: One qualifying pin edge yields exactly one single-cycle strobe. Edges of the opposite polarity yield none, and so do pin edges while a non-pin code is selected.
- R8: A high `pre_clr` at a clock edge sets the prescaler count to zero. It does not disturb the synchronizer or the pin-edge strobes.
- R9: A high `rst` at a clock edge clears the prescaler, the synchronizer flops and `cnt_en`.
- R10: A new `src_sel` value governs `cnt_en` from the next clock edge on. It needs no alignment to a prescaler boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 3 | Count source select code |
| pre_clr | input | 1 | Prescaler restart strobe |
| ext_pin | input | 1 | Raw external count pin, asynchronous |
| cnt_en | output | 1 | Single-cycle count-enable strobe |

## Verification
The bench walks through every select code while the pin toggles with pulse widths from one to seven cycles and prescaler restarts land at arbitrary phases. It also switches codes in mid-period and applies a reset while the pin is high.

Each of these cases catches a different fault:
- A tap decoded from the wrong bit range shows up as a strobe count that is off against 2048/N.
- A prescaler that pauses outside divided modes shifts the phase after a code change.
- Edge detection taken from the first synchronizer flop makes the strobe arrive one cycle early.
- A swapped polarity makes the strobe fire on the wrong pin transition.
- Level detection instead of edge detection produces multi-cycle strobes.

// File: rtl/tmr_clk_select.sv
module tmr_clk_select #(
  parameter int PRE_W  = 10,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] src_sel,
  input  logic       pre_clr,
  input  logic       ext_pin,
  output logic       cnt_en
);
  localparam int TAP8    = 3;
  localparam int TAP64   = 6;
  localparam int TAP256  = 8;
  localparam int TAP1024 = PRE_W;

  logic [PRE_W-1:0]  pre_q;
  logic [SYNC_N-1:0] sync_q;
  logic              edge_q;
  logic              pin_s;
  logic              en_d;

  assign pin_s = sync_q[SYNC_N-1];

  always_comb begin
    unique case (src_sel)
      3'd0:    en_d = 1'b0;
      3'd1:    en_d = 1'b1;
      3'd2:    en_d = &pre_q[TAP8-1:0];
      3'd3:    en_d = &pre_q[TAP64-1:0];
      3'd4:    en_d = &pre_q[TAP256-1:0];
      3'd5:    en_d = &pre_q[TAP1024-1:0];
      3'd6:    en_d = edge_q & ~pin_s;
      default: en_d = pin_s & ~edge_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      sync_q <= '0;
      edge_q <= 1'b0;
      cnt_en <= 1'b0;
    end else begin
      pre_q  <= pre_clr ? '0 : pre_q + 1'b1;
      sync_q <= {sync_q[SYNC_N-2:0], ext_pin};
      edge_q <= pin_s;
      cnt_en <= en_d;
    end
  end

  a_r1_stopped: assert property (@(posedge clk) disable iff (rst)
    src_sel == 3'd0 |=> !cnt_en);
  a_r2_every_clock: assert property (@(posedge clk) disable iff (rst)
    src_sel == 3'd1 |=> cnt_en);
  a_r3_div8_tap: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 3'd2 && pre_q[2:0] == 3'b111) |=> cnt_en);
  a_r3_div1024_quiet: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 3'd5 && pre_q != {PRE_W{1'b1}}) |=> !cnt_en);
  a_r6_rise_seen: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 3'd7 && pin_s && !edge_q) |=> cnt_en);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (src_sel[2:1] == 2'b11 && cnt_en && $past(src_sel[2:1]) == 2'b11) |=> !cnt_en || src_sel[2:1] != 2'b11);
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    pre_clr |=> pre_q == '0);
endmodule

// File: tb/tmr_clk_select_tb.sv
`timescale 1ns/1ps
module tmr_clk_select_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] src_sel = 3'd0;
  logic pre_clr = 1'b0;
  logic ext_pin = 1'b0;
  logic cnt_en;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tmr_clk_select u_dut (
    .clk(clk), .rst(rst), .src_sel(src_sel),
    .pre_clr(pre_clr), .ext_pin(ext_pin), .cnt_en(cnt_en)
  );

  // Reference: prescaler as an arithmetic count, pin as a sample delay line
  int unsigned p = 0;
  logic h1 = 0, h2 = 0, h3 = 0;
  logic exp_en = 0;
  logic e;

  function automatic logic tap(int unsigned v, int bits);
    return (v % (1 << bits)) == ((1 << bits) - 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      p = 0; h1 = 0; h2 = 0; h3 = 0; exp_en = 0;
    end else begin
      case (src_sel)
        3'd0: e = 0;
        3'd1: e = 1;
        3'd2: e = tap(p, 3);
        3'd3: e = tap(p, 6);
        3'd4: e = tap(p, 8);
        3'd5: e = tap(p, 10);
        3'd6: e = !h2 && h3;
        default: e = h2 && !h3;
      endcase
      h3 = h2; h2 = h1; h1 = ext_pin;
      p = pre_clr ? 0 : (p + 1) % 1024;
      exp_en = e;
    end
  end

  function automatic string req_of(logic [2:0] s);
    case (s)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd6: return "R5";
      3'd7: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input logic got, input logic want, input string req);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: cnt_en=%0b expected %0b at %0t", req, got, want, $time);
    end
  endtask

  logic [2:0] last_sel = 3'd0;
  logic       clr_seen = 0;

  task automatic step_check();
    string r;
    @(negedge clk);
    r = req_of(last_sel);
    if (clr_seen && last_sel >= 3'd2 && last_sel <= 3'd5) r = "R8";
    check(cnt_en, exp_en, r);
    last_sel = src_sel;
    clr_seen = pre_clr;
  endtask

  initial begin : watchdog
    #(1_000_000);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int w;
    int cnt;
    int pulses;
    int model_pulses;
    // R9: reset state
    repeat (3) @(negedge clk);
    check(cnt_en, 1'b0, "R9");
    rst = 1'b0;
    w = 1; cnt = 0;
    // Sweep every code; pin toggles with rotating widths, restarts at odd phases
    for (int s = 0; s < 8; s++) begin
      src_sel = 3'(s);          // R10: takes effect on next edge
      pulses = 0; model_pulses = 0;
      for (int i = 0; i < 2100; i++) begin
        step_check();
        if (cnt_en) pulses++;
        if (exp_en) model_pulses++;
        pre_clr = ((i % 700) == 123 + s);
        cnt++;
        if (cnt >= w) begin
          cnt = 0; ext_pin = ~ext_pin;
          w = (w % 7) + 1;
        end
        if (s == 7 && i == 1000) begin
          ext_pin = 1'b1; rst = 1'b1;   // R9 reset with pin high
        end else if (s == 7 && i == 1002) rst = 1'b0;
        if (s == 4 && i == 1500) src_sel = 3'd3;   // R10 mid-period switch
        if (s == 4 && i == 1517) src_sel = 3'd4;
      end
      if (s >= 6) begin
        // R7: one strobe per qualifying edge
        checks++;
        if (pulses != model_pulses) begin
          fails++;
          $display("FAIL R7: pulses=%0d expected %0d", pulses, model_pulses);
        end
      end
    end
    // R4: exact strobe count over 2048 cycles after a restart
    ext_pin = 1'b0;
    for (int s = 2; s <= 5; s++) begin
      int n;
      n = (s == 2) ? 8 : (s == 3) ? 64 : (s == 4) ? 256 : 1024;
      src_sel = 3'd0; pre_clr = 1'b1;
      step_check();
      pre_clr = 1'b0; src_sel = 3'(s);
      step_check();
      pulses = 0;
      for (int i = 0; i < 2048; i++) begin
        step_check();
        if (cnt_en) pulses++;
      end
      checks++;
      if (pulses != 2048 / n) begin
        fails++;
        $display("FAIL R4: pulses=%0d expected %0d for divide %0d", pulses, 2048 / n, n);
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule